// File: doc/BRIEF.md
# Serial Set/Reset Control Chain

This block gives a tester direct control over the state of a small sequential design while adding only three pins: a shift clock, a serial data input and a serial data output. A shift register with two stages per functional flip-flop sits beside the design. Each pair of stages drives one flip-flop's asynchronous force-to-one line and its asynchronous force-to-zero line. The tester shifts a pattern in to preload the state. It then shifts in all zeros to release the lines, and after that the functional clock runs the design normally.

The block also contains a demonstration design. It has two functional flip-flops, three primary inputs and one primary output, and it is wired so that every state bit can be seen at the output. The shift register has its own clock. The functional clock is held idle while bits are being shifted.

Top module: `ssr_access_top`

## Requirements
- R1: The chain has two stages per functional flip-flop, which gives four stages for two flip-flops. Stage 1 forces flip-flop F1 to one, stage 2 forces F1 to zero, stage 3 forces F2 to one and stage 4 forces F2 to zero. Each stage is active high. The serial input enters stage 4 and moves toward stage 1, so after four edges the first bit shifted in sits in stage 1.
- R2: The chain advances one stage per rising edge of `shift_clk`. `ser_out` is stage 1, so it shows the bit that was presented at `ser_in` four shift edges earlier.
- R3: With `rst` high, a rising shift-clock edge clears every stage, and a rising functional-clock edge clears both flip-flops whose force lines are low. After reset, `out_y` is 0 for every input combination.
- R4: Shifting in 1,0,1,0 forces both flip-flops to 1 as soon as the load completes, with no functional-clock edge.
- R5: Shifting in 0,0,0,0 after that load releases every force line, and both flip-flops keep the value 1.
- R6: With all force lines low, each functional-clock edge loads F1 with `in_b XOR F2` and F2 with `in_c OR (in_a AND F1)`.
- R7: When a flip-flop's force-to-one and force-to-zero lines are both high, force-to-zero wins. Loading 1,1,1,1 leaves both flip-flops at 0.
- R8: `out_y` is F1 AND F2 when `in_a`=1 and `in_b`=1, and 0 when `in_a`=1 and `in_b`=0. With `in_a`=0 it is F1 when `in_b`=1 and F2 when `in_b`=0.
- R9: The two flip-flops are forced independently. Loading 1,0,0,1 gives F1=1 and F2=0.
- R10: While the chain holds only zeros, further shift edges leave the flip-flop state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| func_clk | input | 1 | Functional clock of the demonstration design |
| shift_clk | input | 1 | Clock of the control chain |
| rst | input | 1 | Synchronous active-high reset, seen by both clocks |
| ser_in | input | 1 | Serial test data into stage 4 |
| ser_out | output | 1 | Serial test data out of stage 1 |
| in_a | input | 1 | Primary input a |
| in_b | input | 1 | Primary input b |
| in_c | input | 1 | Primary input c |
| out_y | output | 1 | Primary output |

## Verification
Force effects are asynchronous. A forced value is therefore due right after the shift edge that completes a load, without any functional edge, and the bench samples it at the following falling edge. `ser_out` is due after the fourth shift edge that follows a bit's entry, and each flip-flop update is due after one functional edge. Every clock edge is produced by gating a 50 MHz clock, with enables changed only on falling edges. All results are read on a falling edge, once the edge that produces them has passed. Because `out_y` is combinational, the state is read by changing the inputs between edges.

// File: rtl/ssr_pkg.sv
package ssr_pkg;

    localparam int NUM_FF      = 2;
    localparam int LINES_PER_FF = 2;
    localparam int CHAIN_LEN   = NUM_FF * LINES_PER_FF;

    // Force lines for one functional flip-flop.
    typedef struct packed {
        logic clr;
        logic set;
    } force_t;

    typedef logic [NUM_FF-1:0] state_t;

    // Next state of the demonstration design (index 0 = F1, 1 = F2).
    function automatic state_t demo_next(state_t q, logic a, logic b, logic c);
        state_t r;
        r[0] = b ^ q[1];
        r[1] = c | (a & q[0]);
        return r;
    endfunction

    // Primary output: fault path when a=1, state observation when a=0.
    function automatic logic demo_out(state_t q, logic a, logic b);
        logic r;
        if (a) r = b & q[0] & q[1];
        else   r = b ? q[0] : q[1];
        return r;
    endfunction

endpackage

// File: rtl/ssr_chain.sv
module ssr_chain
    import ssr_pkg::*;
#(
    parameter int N_FF = NUM_FF
) (
    input  logic                 shift_clk,
    input  logic                 rst,
    input  logic                 ser_in,
    output logic                 ser_out,
    output force_t [N_FF-1:0]    lines_o
);

    localparam int LEN = N_FF * LINES_PER_FF;

    // stg[0] is stage 1 (nearest the output), stg[LEN-1] takes ser_in.
    logic [LEN-1:0] stg;

    always_ff @(posedge shift_clk) begin
        if (rst) stg <= '0;
        else     stg <= {ser_in, stg[LEN-1:1]};
    end

    assign ser_out = stg[0];

    for (genvar i = 0; i < N_FF; i++) begin : g_map
        assign lines_o[i].set = stg[LINES_PER_FF*i];
        assign lines_o[i].clr = stg[LINES_PER_FF*i + 1];
    end

    // R2: new bit lands in the last stage
    p_shift_in_r2: assert property (@(posedge shift_clk) disable iff (rst)
        !$past(rst) |-> stg[LEN-1] == $past(ser_in));

    // R2: every other stage takes its neighbour's previous value
    p_advance_r2: assert property (@(posedge shift_clk) disable iff (rst)
        !$past(rst) |-> stg[LEN-2:0] == $past(stg[LEN-1:1]));

endmodule

// File: rtl/ssr_flop.sv
module ssr_flop (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic d,
    output logic q
);

    // Clear beats set; both beat the clocked path.
    always_ff @(posedge clk or posedge set_i or posedge clr_i) begin
        if (clr_i)      q <= 1'b0;
        else if (set_i) q <= 1'b1;
        else if (rst)   q <= 1'b0;
        else            q <= d;
    end

    // R7: an active clear line always holds the flop at zero
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
        clr_i |-> q == 1'b0);

    // R4: set alone holds the flop at one
    p_set_forces_r4: assert property (@(posedge clk) disable iff (rst)
        (set_i && !clr_i) |-> q == 1'b1);

endmodule

// File: rtl/ssr_access_top.sv
module ssr_access_top
    import ssr_pkg::*;
(
    input  logic func_clk,
    input  logic shift_clk,
    input  logic rst,
    input  logic ser_in,
    output logic ser_out,
    input  logic in_a,
    input  logic in_b,
    input  logic in_c,
    output logic out_y
);

    force_t [NUM_FF-1:0] lines;
    state_t              q;
    state_t              nxt;

    ssr_chain #(.N_FF(NUM_FF)) u_chain (
        .shift_clk (shift_clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .ser_out   (ser_out),
        .lines_o   (lines)
    );

    assign nxt = demo_next(q, in_a, in_b, in_c);

    for (genvar i = 0; i < NUM_FF; i++) begin : g_ff
        ssr_flop u_ff (
            .clk   (func_clk),
            .rst   (rst),
            .set_i (lines[i].set),
            .clr_i (lines[i].clr),
            .d     (nxt[i]),
            .q     (q[i])
        );
    end

    assign out_y = demo_out(q, in_a, in_b);

endmodule

// File: tb/test_ssr_access_top.sv
module test_ssr_access_top;

    logic clk = 1'b0;
    logic sen = 1'b0, fen = 1'b0;
    logic rst = 1'b1;
    logic ser_in = 1'b0;
    logic in_a = 1'b0, in_b = 1'b0, in_c = 1'b0;
    logic ser_out, out_y;
    logic func_clk, shift_clk;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // bench model
    logic mq1 = 1'b0, mq2 = 1'b0;
    logic [3:0] mch = 4'b0;   // mch[0] = stage 1

    always #10 clk = ~clk;    // 50 MHz
    assign shift_clk = clk & sen;
    assign func_clk  = clk & fen;

    ssr_access_top i_ssr_access_top (
        .func_clk (func_clk), .shift_clk (shift_clk), .rst (rst),
        .ser_in (ser_in), .ser_out (ser_out),
        .in_a (in_a), .in_b (in_b), .in_c (in_c), .out_y (out_y)
    );

    task automatic check(input logic got, input logic exp, input string req, input string what);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk); ser_in = b; sen = 1'b1;
        @(negedge clk); sen = 1'b0;
        if (!rst) begin
            mch = {b, mch[3:1]};
            if (mch[1]) mq1 = 1'b0; else if (mch[0]) mq1 = 1'b1;
            if (mch[3]) mq2 = 1'b0; else if (mch[2]) mq2 = 1'b1;
        end
    endtask

    task automatic load4(input logic b1, input logic b2, input logic b3, input logic b4);
        shift_bit(b1); shift_bit(b2); shift_bit(b3); shift_bit(b4);
    endtask

    task automatic func_step(input logic a, input logic b, input logic c);
        logic n1, n2;
        @(negedge clk); in_a = a; in_b = b; in_c = c; fen = 1'b1;
        @(negedge clk); fen = 1'b0;
        n1 = b ^ mq2;
        n2 = c | (a & mq1);
        mq1 = n1; mq2 = n2;
    endtask

    function automatic logic y_exp(input logic a, input logic b);
        if (a) return b & mq1 & mq2;
        return b ? mq1 : mq2;
    endfunction

    task automatic observe(input string req);
        in_a = 1'b0; in_b = 1'b1; #1; check(out_y, mq1, req, "F1 via out_y");
        in_b = 1'b0;              #1; check(out_y, mq2, req, "F2 via out_y");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        shift_bit(1'b0);
        func_step(1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        mq1 = 1'b0; mq2 = 1'b0; mch = 4'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check(ser_out, 1'b0, "R3", "ser_out after reset");
        for (int k = 0; k < 8; k++) begin
            in_a = k[0]; in_b = k[1]; in_c = k[2]; #1;
            check(out_y, 1'b0, "R3", "out_y after reset");
        end
    endtask

    task automatic t_stream();
        logic [7:0] bits = 8'b0100_1011;  // bits[0] shifted first
        for (int k = 0; k < 8; k++) begin
            shift_bit(bits[k]);
            if (k >= 3) check(ser_out, bits[k-3], "R2", "ser_out four edges later");
            else        check(ser_out, 1'b0, "R2", "ser_out before stream arrives");
        end
        do_reset();
    endtask

    task automatic t_force_ones();
        load4(1'b1, 1'b0, 1'b1, 1'b0);
        check(ser_out, 1'b1, "R1", "first bit sits in stage 1");
        observe("R4");
        in_a = 1'b1; in_b = 1'b1; in_c = 1'b0; #1;
        check(out_y, 1'b1, "R8", "fault path a=1 b=1");
        in_b = 1'b0; #1;
        check(out_y, 1'b0, "R8", "a=1 b=0");
    endtask

    task automatic t_release();
        load4(1'b0, 1'b0, 1'b0, 1'b0);
        observe("R5");
        shift_bit(1'b0); shift_bit(1'b0);
        observe("R10");
    endtask

    task automatic t_run();
        logic [2:0] pat [6] = '{3'b011, 3'b100, 3'b001, 3'b110, 3'b000, 3'b101};
        for (int k = 0; k < 6; k++) begin
            func_step(pat[k][0], pat[k][1], pat[k][2]);
            in_a = 1'b1; in_b = 1'b1; #1;
            check(out_y, y_exp(1'b1, 1'b1), "R8", "out_y a=1 b=1 in run");
            observe("R6");
        end
        shift_bit(1'b0);
        observe("R10");
    endtask

    task automatic t_mixed();
        do_reset();
        load4(1'b1, 1'b0, 1'b0, 1'b1);
        check(mq1, 1'b1, "R9", "model F1");
        observe("R9");
    endtask

    task automatic t_conflict();
        load4(1'b1, 1'b1, 1'b1, 1'b1);
        in_a = 1'b0; in_b = 1'b1; #1; check(out_y, 1'b0, "R7", "F1 with both lines high");
        in_b = 1'b0;              #1; check(out_y, 1'b0, "R7", "F2 with both lines high");
        do_reset();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_stream();
        t_force_ones();
        t_release();
        t_run();
        t_mixed();
        t_conflict();
        finish_run();
    end

endmodule